// File: doc/BRIEF.md
# Interrupt Event Collector with Mask and Summaries

This block gathers single-cycle event pulses from a storage-card host controller's command path, data path, FIFO and card-detect logic into a sticky 32-bit pending register. Software clears pending bits by writing ones to them. A separate 32-bit enable-mask register picks which pending bits may raise an interrupt. The block computes the masked view continuously as pending AND mask.

One level interrupt request leaves the block. It is high only while a global interrupt-enable flag is set and at least one masked bit is high. Two further level outputs summarise the masked view. One covers the error group and the other covers the completion group, so a handler can tell at a glance whether a transfer finished or failed.

The event map is fixed:

| Bit | Event |
|-----|-------|
| 1 | response error |
| 2 | command done |
| 3 | data over |
| 4 | transmit request |
| 5 | receive request |
| 6 | response CRC error |
| 7 | data CRC error |
| 8 | response timeout |
| 9 | data timeout |
| 10 | voltage switch done |
| 11 | FIFO run error |
| 12 | hardware locked |
| 13 | start-bit error |
| 14 | auto-command done |
| 15 | end-bit error |
| 16 | SDIO card interrupt |
| 30 | card inserted |
| 31 | card removed |

Top module: `irq_status_unit`

## Requirements
- R1: After reset the pending register, the mask register, the masked view, the interrupt request and both summaries are all zero.
- R2: A pulse on `evt_i` at an implemented position (1 to 16, 30, 31) sets that pending bit at the next clock edge. The bit then stays set until it is cleared.
- R3: Pending bits at positions 0 and 17 to 29 never become set, whatever pulses arrive.
- R4: When `clr_we_i` is high, every pending bit whose `clr_data_i` bit is 1 is cleared at the next edge. Pending bits whose `clr_data_i` bit is 0 keep their value.
- R5: An event and a clear of the same bit in the same cycle leave that bit set.
- R6: When `mask_we_i` is high, the mask register loads `mask_data_i` at the next edge. `masked_o` always equals pending AND mask.
- R7: The interrupt-enable flag loads `irq_en_wdata_i` at an edge where `irq_en_we_i` is high. `irq_o` is high exactly when the flag is set and `masked_o` is non-zero.
- R8: `err_sum_o` is the OR of masked bits 1, 6, 7, 8, 9, 11, 12, 13 and 15.
- R9: `done_sum_o` is the OR of masked bits 2, 3, 10 and 14.
- R10: The mask does not affect capture. An event whose mask bit is 0 is still recorded in `raw_o`, but it raises neither `masked_o` nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | Single-cycle event pulses, one per bit position |
| clr_we_i | input | 1 | Write strobe for write-one-to-clear of the pending register |
| clr_data_i | input | 32 | Ones select the pending bits to clear |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_data_i | input | 32 | New mask value |
| irq_en_we_i | input | 1 | Write strobe for the global interrupt-enable flag |
| irq_en_wdata_i | input | 1 | New value of the global interrupt-enable flag |
| raw_o | output | 32 | Pending (raw) status |
| mask_o | output | 32 | Current mask register |
| masked_o | output | 32 | Pending AND mask |
| irq_o | output | 1 | Level interrupt request |
| err_sum_o | output | 1 | Error-group summary of the masked view |
| done_sum_o | output | 1 | Completion-group summary of the masked view |

## Verification
The hardest case to reach from the ports is a single edge where an event pulse and a clear strobe hit the same bit while that bit is already pending. The stimulus reaches it by first loading the bit, then driving the event and the clear in the same cycle, so that the rule that set wins over clear is checked directly.

The sweeps drive each of the 32 positions one at a time, with the mask fully open. This shows which positions are implemented and which summary group each belongs to. A second sweep holds every implemented bit pending and opens one mask bit at a time, with the enable flag both on and off.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned EVT_W = 32;

  localparam int unsigned B_RSP_ERR  = 1;
  localparam int unsigned B_CMD_DONE = 2;
  localparam int unsigned B_DAT_OVER = 3;
  localparam int unsigned B_TX_REQ   = 4;
  localparam int unsigned B_RX_REQ   = 5;
  localparam int unsigned B_RSP_CRC  = 6;
  localparam int unsigned B_DAT_CRC  = 7;
  localparam int unsigned B_RSP_TO   = 8;
  localparam int unsigned B_DAT_TO   = 9;
  localparam int unsigned B_VOLT_OK  = 10;
  localparam int unsigned B_FIFO_ERR = 11;
  localparam int unsigned B_HW_LOCK  = 12;
  localparam int unsigned B_SBIT_ERR = 13;
  localparam int unsigned B_AUTO_OK  = 14;
  localparam int unsigned B_EBIT_ERR = 15;
  localparam int unsigned B_SDIO     = 16;
  localparam int unsigned B_CARD_IN  = 30;
  localparam int unsigned B_CARD_OUT = 31;

  function automatic logic [EVT_W-1:0] bit_at(input int unsigned idx);
    return EVT_W'(1) << idx;
  endfunction

  // contiguous run of ones from lo to hi inclusive
  function automatic logic [EVT_W-1:0] span(input int unsigned lo, input int unsigned hi);
    logic [EVT_W-1:0] v;
    v = '0;
    for (int unsigned k = 0; k < EVT_W; k++)
      if (k >= lo && k <= hi) v[k] = 1'b1;
    return v;
  endfunction

  localparam logic [EVT_W-1:0] IMPL_BITS =
    span(B_RSP_ERR, B_SDIO) | bit_at(B_CARD_IN) | bit_at(B_CARD_OUT);

  localparam logic [EVT_W-1:0] ERR_BITS =
    bit_at(B_RSP_ERR) | bit_at(B_RSP_CRC) | bit_at(B_DAT_CRC) |
    bit_at(B_RSP_TO)  | bit_at(B_DAT_TO)  | bit_at(B_FIFO_ERR) |
    bit_at(B_HW_LOCK) | bit_at(B_SBIT_ERR) | bit_at(B_EBIT_ERR);

  localparam logic [EVT_W-1:0] DONE_BITS =
    bit_at(B_CMD_DONE) | bit_at(B_DAT_OVER) | bit_at(B_VOLT_OK) | bit_at(B_AUTO_OK);

  // next pending value: clear selected bits, then let new events win
  function automatic logic [EVT_W-1:0] next_pending(
      input logic [EVT_W-1:0] cur, input logic [EVT_W-1:0] clr,
      input logic [EVT_W-1:0] evt, input logic [EVT_W-1:0] impl);
    return ((cur & ~clr) | evt) & impl;
  endfunction

  function automatic logic group_hit(input logic [EVT_W-1:0] v, input logic [EVT_W-1:0] grp);
    return |(v & grp);
  endfunction
endpackage

// File: rtl/isu_pending_bank.sv
module isu_pending_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] pending,
  output logic [W-1:0] clr_eff
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  assign clr_eff = clr_we ? clr_data : '0;
  assign pend_d  = ((pend_q & ~clr_eff) | evt) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/isu_wr_reg.sv
module isu_wr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/isu_combine.sv
module isu_combine #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] ERR_GRP = '0,
  parameter logic [W-1:0] DONE_GRP = '0
) (
  input  logic [W-1:0] pending,
  input  logic [W-1:0] mask,
  input  logic         gie,
  output logic [W-1:0] masked,
  output logic         any_masked,
  output logic         err_sum,
  output logic         done_sum,
  output logic         irq
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign masked[i] = pending[i] & mask[i];
  end

  assign any_masked = |masked;
  assign err_sum    = |(masked & ERR_GRP);
  assign done_sum   = |(masked & DONE_GRP);
  assign irq        = gie & any_masked;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int unsigned W = EVT_W,
  parameter logic [W-1:0] IMPL_MASK = IMPL_BITS,
  parameter logic [W-1:0] ERR_MASK = ERR_BITS,
  parameter logic [W-1:0] DONE_MASK = DONE_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_data_i,
  input  logic         irq_en_we_i,
  input  logic         irq_en_wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o,
  output logic         err_sum_o,
  output logic         done_sum_o
);
  logic [W-1:0] clr_eff;
  logic [0:0]   gie_q;
  logic         any_masked;

  isu_pending_bank #(.W(W), .IMPL(IMPL_MASK)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr_we(clr_we_i),
    .clr_data(clr_data_i), .pending(raw_o), .clr_eff(clr_eff)
  );

  isu_wr_reg #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we_i), .wdata(mask_data_i), .q(mask_o)
  );

  isu_wr_reg #(.W(1)) u_gie (
    .clk(clk), .rst_n(rst_n), .we(irq_en_we_i), .wdata(irq_en_wdata_i), .q(gie_q)
  );

  isu_combine #(.W(W), .ERR_GRP(ERR_MASK), .DONE_GRP(DONE_MASK)) u_comb (
    .pending(raw_o), .mask(mask_o), .gie(gie_q[0]), .masked(masked_o),
    .any_masked(any_masked), .err_sum(err_sum_o), .done_sum(done_sum_o), .irq(irq_o)
  );
endmodule

// File: rtl/isu_chk.sv
module isu_chk #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt_i,
  input logic [W-1:0] clr_eff,
  input logic         mask_we_i,
  input logic [W-1:0] mask_data_i,
  input logic [W-1:0] raw_o,
  input logic [W-1:0] masked_o,
  input logic         any_masked,
  input logic         irq_o
);
  // R2
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw_o) & ~$past(clr_eff)) & ~raw_o) == '0));
  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_i) & IMPL) & ~raw_o) == '0));
  // R4
  clear_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(clr_eff) & ~$past(evt_i))) & raw_o) == '0));
  // R3
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o & ~IMPL) == '0);
  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> ((masked_o & ~$past(mask_data_i)) == '0));
  // R7
  irq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> any_masked);
endmodule

bind irq_status_unit isu_chk #(.W(W), .IMPL(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_eff(clr_eff),
  .mask_we_i(mask_we_i), .mask_data_i(mask_data_i), .raw_o(raw_o),
  .masked_o(masked_o), .any_masked(any_masked), .irq_o(irq_o)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        clr_we_i = 1'b0;
  logic [31:0] clr_data_i = '0;
  logic        mask_we_i = 1'b0;
  logic [31:0] mask_data_i = '0;
  logic        irq_en_we_i = 1'b0;
  logic        irq_en_wdata_i = 1'b0;
  logic [31:0] raw_o, mask_o, masked_o;
  logic        irq_o, err_sum_o, done_sum_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] impl, errg, doneg;
  logic [31:0] m_raw, m_mask;
  logic        m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_we_i(clr_we_i),
    .clr_data_i(clr_data_i), .mask_we_i(mask_we_i), .mask_data_i(mask_data_i),
    .irq_en_we_i(irq_en_we_i), .irq_en_wdata_i(irq_en_wdata_i),
    .raw_o(raw_o), .mask_o(mask_o), .masked_o(masked_o), .irq_o(irq_o),
    .err_sum_o(err_sum_o), .done_sum_o(done_sum_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, edge, release at next negedge; update model
  task automatic cyc(input logic [31:0] ev, input logic cwe, input logic [31:0] cd,
                     input logic mwe, input logic [31:0] md,
                     input logic ewe, input logic ed);
    evt_i = ev; clr_we_i = cwe; clr_data_i = cd;
    mask_we_i = mwe; mask_data_i = md; irq_en_we_i = ewe; irq_en_wdata_i = ed;
    @(posedge clk);
    @(negedge clk);
    evt_i = '0; clr_we_i = 1'b0; clr_data_i = '0;
    mask_we_i = 1'b0; mask_data_i = '0; irq_en_we_i = 1'b0; irq_en_wdata_i = 1'b0;
    if (cwe) m_raw = m_raw & ~cd;
    m_raw = (m_raw | ev) & impl;
    if (mwe) m_mask = md;
    if (ewe) m_en = ed;
  endtask

  task automatic check_outputs(input string tag);
    logic [31:0] mv;
    mv = m_raw & m_mask;
    chk({tag, " R2 raw"}, raw_o, m_raw);
    chk({tag, " R6 masked"}, masked_o, mv);
    chk({tag, " R7 irq"}, {31'b0, irq_o}, {31'b0, m_en && (mv != 0)});
    chk({tag, " R8 err"}, {31'b0, err_sum_o}, {31'b0, (mv & errg) != 0});
    chk({tag, " R9 done"}, {31'b0, done_sum_o}, {31'b0, (mv & doneg) != 0});
  endtask

  initial begin
    impl = '0;
    for (int b = 1; b <= 16; b++) impl[b] = 1'b1;
    impl[30] = 1'b1; impl[31] = 1'b1;
    errg = '0;
    foreach (errg[b]) if (b == 1 || b == 6 || b == 7 || b == 8 || b == 9 ||
                          b == 11 || b == 12 || b == 13 || b == 15) errg[b] = 1'b1;
    doneg = (32'd1 << 2) | (32'd1 << 3) | (32'd1 << 10) | (32'd1 << 14);
    m_raw = '0; m_mask = '0; m_en = 1'b0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 raw", raw_o, '0);
    chk("R1 mask", mask_o, '0);
    chk("R1 masked", masked_o, '0);
    chk("R1 irq/sums", {29'b0, irq_o, err_sum_o, done_sum_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // open mask and enable
    cyc('0, 1'b0, '0, 1'b1, '1, 1'b1, 1'b1);
    chk("R6 mask load", mask_o, '1);

    // sweep every position alone (R2, R3, R8, R9)
    for (int i = 0; i < 32; i++) begin
      cyc(32'd1 << i, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
      check_outputs("sweep");
      chk("R3 impl position", raw_o, impl & (32'd1 << i));
      cyc('0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
      chk("R2 sticky", raw_o, m_raw);
      cyc('0, 1'b1, 32'd1 << i, 1'b0, '0, 1'b0, 1'b0);
      chk("R4 cleared", raw_o, '0);
      chk("R7 irq low after clear", {31'b0, irq_o}, 32'd0);
    end

    // all events pending, one mask bit at a time, enable on and off
    cyc('1, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    chk("R3 unimpl never set", raw_o & ~impl, '0);
    for (int i = 0; i < 32; i++) begin
      cyc('0, 1'b0, '0, 1'b1, 32'd1 << i, 1'b1, 1'b1);
      check_outputs("mask sweep");
      cyc('0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
      chk("R7 enable off", {31'b0, irq_o}, 32'd0);
      check_outputs("mask sweep off");
    end

    // R4 partial clear
    cyc('1, 1'b1, '1, 1'b1, '1, 1'b1, 1'b1);
    cyc('0, 1'b1, '1, 1'b0, '0, 1'b0, 1'b0);
    cyc((32'd1 << 2) | (32'd1 << 3) | (32'd1 << 8), 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    cyc('0, 1'b1, 32'h0000_0104, 1'b0, '0, 1'b0, 1'b0);
    chk("R4 partial clear", raw_o, 32'h0000_0008);
    check_outputs("R4 partial");

    // R5 set and clear same bit, bit already pending
    cyc(32'd1 << 3, 1'b1, 32'd1 << 3, 1'b0, '0, 1'b0, 1'b0);
    chk("R5 set wins pending", raw_o, 32'h0000_0008);
    // R5 on a clear bit, while another bit is cleared
    cyc(32'd1 << 9, 1'b1, (32'd1 << 9) | (32'd1 << 3), 1'b0, '0, 1'b0, 1'b0);
    chk("R5 set wins fresh", raw_o, 32'h0000_0200);
    check_outputs("R5");

    // R10 capture with mask closed
    cyc('0, 1'b1, '1, 1'b1, '0, 1'b0, 1'b0);
    cyc(32'd1 << 6, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    chk("R10 raw captured", raw_o, 32'h0000_0040);
    chk("R10 masked zero", masked_o, '0);
    chk("R10 irq low", {31'b0, irq_o}, 32'd0);
    cyc('0, 1'b0, '0, 1'b1, 32'h0000_0040, 1'b0, 1'b0);
    chk("R10 later unmask", masked_o, 32'h0000_0040);
    check_outputs("R10");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule